// File: doc/BRIEF.md
# SDRAM Bank Policy Command Sequencer

This block sits between one internal requester and the command pins of an SDRAM controller. It accepts one read or write request at a time through a valid/ready handshake. For each request it emits the row activate, column read or write, and precharge commands, each in its own cycle, with the bank and address that go with it. When it has no command to issue it drives the deselect code.

A policy input, sampled when each request is accepted, chooses where precharges go. With the open policy a row stays open after its access. A later request to the same bank and row then goes straight to the column command. A request to a different row or a different bank first precharges the open bank. With the closed policy every access ends with a precharge of its own bank. If a row is still open when a closed-policy request arrives, that row is precharged first. Precharge-to-activate, activate-to-column and write-recovery spacing come from cycle parameters.

Top module: `sdram_bank_seq`

## Requirements
- R1: When no command is due, `cmd` is deselect (code 0) with `cmd_bank` and `cmd_addr` zero. The other codes are activate 1, read 2, write 3 and precharge 4.
- R2: `req_ready` is high while idle. It drops in the cycle after a request is accepted and stays low through the cycle that carries `done`. It is high again in the following cycle.
- R3: The first command of a sequence appears in the cycle after acceptance, unless a timing rule (R10 to R12) holds it back.
- R4: With the open policy a sequence ends with its read or write, and `done` is high in that cycle. No precharge follows.
- R5: With the open policy, a request whose bank and row match the open row issues no activate. The read or write comes first.
- R6: When a request names a bank other than the open one, the open bank is precharged before the new bank is activated.
- R7: A request to the open bank with a different row also precharges that bank, then activates the new row.
- R8: With the closed policy, the read or write is followed by a precharge of the same bank, and `done` is high in that precharge cycle. The policy is taken from `close_pol` at acceptance.
- R9: A closed-policy request that finds a row open precharges it first, even when bank and row match.
- R10: An activate is at least T_RP cycles after the previous precharge.
- R11: A read or write is at least T_RCD cycles after the activate.
- R12: A precharge is at least T_WR cycles after the previous write.
- R13: Activate carries the row on `cmd_addr`. Read and write carry the zero-extended column. Precharge carries address 0. Every command carries its target bank on `cmd_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| close_pol | input | 1 | 1 = closed policy, 0 = open policy |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd | output | 3 | Command code |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | max(ROW_W,COL_W) | Row, column or zero |
| done | output | 1 | Last command of the sequence |

## Verification
The bench mixes row hits, row misses in the same bank and misses to other banks. It also flips the policy while a row is open. A design that skipped the first precharge on a policy switch would activate a bank that was never closed. A design that compared only the bank would read the wrong row. Reads right after a write, and precharges right after a write, probe the recovery counter. That counter must delay the precharge and leave a hit read alone. A wrong counter shows up as a command one cycle early or a stray deselect. Back-to-back requests catch a design that lets the spacing counters reset between requests, because it would issue an activate too soon after the previous precharge.

// File: rtl/sdram_bank_seq.sv
module sdram_bank_seq #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 2,
  parameter int T_WR   = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_pol,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              done
);
  localparam logic [2:0] CMD_DESEL = 3'd0;
  localparam logic [2:0] CMD_ACT   = 3'd1;
  localparam logic [2:0] CMD_RD    = 3'd2;
  localparam logic [2:0] CMD_WR    = 3'd3;
  localparam logic [2:0] CMD_PRE   = 3'd4;
  localparam int TMAX = (T_RP > T_RCD) ? ((T_RP > T_WR) ? T_RP : T_WR)
                                       : ((T_RCD > T_WR) ? T_RCD : T_WR);
  localparam int CW = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE_OLD, S_ACT, S_RW, S_PRE_CLOSE} st_t;

  st_t              st;
  logic [CW-1:0]    cnt, wr_cnt;
  logic             open_vld;
  logic [BANK_W-1:0] open_bank, r_bank;
  logic [ROW_W-1:0] open_row, r_row;
  logic [COL_W-1:0] r_col;
  logic             r_write, r_close;
  logic             hit, fire, is_pre;

  assign hit       = open_vld && open_bank == req_bank && open_row == req_row;
  assign is_pre    = st == S_PRE_OLD || st == S_PRE_CLOSE;
  assign fire      = is_pre ? (cnt == '0 && wr_cnt == '0)
                   : (st == S_ACT || st == S_RW) ? cnt == '0 : 1'b0;
  assign req_ready = st == S_IDLE;
  assign done      = fire && (st == S_PRE_CLOSE || (st == S_RW && !r_close));

  always_comb begin
    cmd      = CMD_DESEL;
    cmd_bank = '0;
    cmd_addr = '0;
    if (fire) begin
      case (st)
        S_PRE_OLD:   begin cmd = CMD_PRE; cmd_bank = open_bank; end
        S_PRE_CLOSE: begin cmd = CMD_PRE; cmd_bank = r_bank; end
        S_ACT:       begin cmd = CMD_ACT; cmd_bank = r_bank; cmd_addr = ADDR_W'(r_row); end
        S_RW:        begin
          cmd      = r_write ? CMD_WR : CMD_RD;
          cmd_bank = r_bank;
          cmd_addr = ADDR_W'(r_col);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      wr_cnt    <= '0;
      open_vld  <= 1'b0;
      open_bank <= '0;
      open_row  <= '0;
      r_bank    <= '0;
      r_row     <= '0;
      r_col     <= '0;
      r_write   <= 1'b0;
      r_close   <= 1'b0;
    end else begin
      if (fire && is_pre)                  cnt <= CW'(T_RP - 1);
      else if (fire && st == S_ACT)        cnt <= CW'(T_RCD - 1);
      else if (cnt != '0)                  cnt <= cnt - 1'b1;

      if (fire && st == S_RW && r_write)   wr_cnt <= CW'(T_WR - 1);
      else if (wr_cnt != '0)               wr_cnt <= wr_cnt - 1'b1;

      case (st)
        S_IDLE: if (req_valid) begin
          r_bank  <= req_bank;
          r_row   <= req_row;
          r_col   <= req_col;
          r_write <= req_write;
          r_close <= close_pol;
          if (open_vld && (close_pol || !hit)) st <= S_PRE_OLD;
          else if (open_vld)                   st <= S_RW;
          else                                 st <= S_ACT;
        end
        S_PRE_OLD: if (fire) begin
          open_vld <= 1'b0;
          st       <= S_ACT;
        end
        S_ACT: if (fire) begin
          open_vld  <= 1'b1;
          open_bank <= r_bank;
          open_row  <= r_row;
          st        <= S_RW;
        end
        S_RW: if (fire) st <= r_close ? S_PRE_CLOSE : S_IDLE;
        S_PRE_CLOSE: if (fire) begin
          open_vld <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [15:0] since_pre, since_act, since_wr;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pre <= 16'hFFFF;
      since_act <= 16'hFFFF;
      since_wr  <= 16'hFFFF;
    end else begin
      since_pre <= (cmd == CMD_PRE) ? 16'd1 : (since_pre == 16'hFFFF ? since_pre : since_pre + 16'd1);
      since_act <= (cmd == CMD_ACT) ? 16'd1 : (since_act == 16'hFFFF ? since_act : since_act + 16'd1);
      since_wr  <= (cmd == CMD_WR)  ? 16'd1 : (since_wr  == 16'hFFFF ? since_wr  : since_wr  + 16'd1);
    end
  end

  p_desel_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd == CMD_DESEL && cmd_addr == '0 && cmd_bank == '0));
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_ready_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  p_done_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd == CMD_RD || cmd == CMD_WR || cmd == CMD_PRE));
  p_trp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |-> since_pre >= 16'(T_RP));
  p_trcd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> since_act >= 16'(T_RCD));
  p_twr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> since_wr >= 16'(T_WR));
endmodule

// File: tb/sdram_bank_seq_bench.sv
module sdram_bank_seq_bench;
  localparam int BANK_W = 2, ROW_W = 13, COL_W = 10;
  localparam int T_RP = 3, T_RCD = 2, T_WR = 4;
  localparam int ADDR_W = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic close_pol = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic req_ready, done;
  logic [2:0] cmd;
  logic [BANK_W-1:0] cmd_bank;
  logic [ADDR_W-1:0] cmd_addr;

  sdram_bank_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
                   .T_RP(T_RP), .T_RCD(T_RCD), .T_WR(T_WR)) u_sdram_bank_seq (
    .clk(clk), .rst_n(rst_n), .close_pol(close_pol), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .cmd(cmd), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .done(done));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // behavioural reference model
  bit m_busy = 0, m_pol = 0, m_open = 0;
  int m_acc = 0, m_ob = 0, m_or = 0;
  int m_lp = -1000, m_la = -1000, m_lw = -1000;
  int a_lp = -1000, a_la = -1000, a_lw = -1000;
  int q_cmd[$], q_bank[$], q_addr[$];
  string q_tag[$];

  task automatic push(int c, int b, int a, string t);
    if (q_cmd.size() == 0) t = {t, "/R3"};
    q_cmd.push_back(c); q_bank.push_back(b); q_addr.push_back(a); q_tag.push_back(t);
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    bit exp_ready, edone, ok;
    int ecmd, eb, ea;
    string etag;
    exp_ready = !m_busy;
    ecmd = 0; eb = 0; ea = 0; edone = 0; etag = "R1/R4";
    if (m_busy && q_cmd.size() > 0 && cyc >= m_acc + 1) begin
      case (q_cmd[0])
        1: ok = cyc >= m_lp + T_RP;
        2, 3: ok = cyc >= m_la + T_RCD;
        default: ok = cyc >= m_lw + T_WR;
      endcase
      if (ok) begin
        ecmd = q_cmd.pop_front(); eb = q_bank.pop_front();
        ea = q_addr.pop_front(); etag = q_tag.pop_front();
        edone = q_cmd.size() == 0;
      end
    end
    chk(req_ready == exp_ready, "R2 ready", req_ready, exp_ready);
    chk(cmd == 3'(ecmd), {etag, " cmd"}, cmd, ecmd);
    chk(cmd_bank == BANK_W'(eb) && cmd_addr == ADDR_W'(ea), "R13 bank/addr",
        {cmd_bank, cmd_addr}, (eb << ADDR_W) | ea);
    chk(done == edone, m_pol ? "R8 done" : "R4 done", done, edone);
    // timing spacing observed at the pins
    if (cmd == 3'd1) begin chk(cyc - a_lp >= T_RP, "R10 tRP", cyc - a_lp, T_RP); a_la = cyc; end
    if (cmd == 3'd2 || cmd == 3'd3) chk(cyc - a_la >= T_RCD, "R11 tRCD", cyc - a_la, T_RCD);
    if (cmd == 3'd4) begin chk(cyc - a_lw >= T_WR, "R12 tWR", cyc - a_lw, T_WR); a_lp = cyc; end
    if (cmd == 3'd3) a_lw = cyc;
    case (ecmd)
      1: begin m_la = cyc; m_open = 1; m_ob = eb; m_or = ea; end
      3: m_lw = cyc;
      4: begin m_lp = cyc; m_open = 0; end
      default: ;
    endcase
    if (edone) m_busy = 0;
    if (exp_ready && req_valid) begin
      bit hit;
      m_busy = 1; m_acc = cyc; m_pol = close_pol;
      hit = m_open && m_ob == int'(req_bank) && m_or == int'(req_row);
      if (m_open && (m_pol || !hit))
        push(4, m_ob, 0, m_pol ? "R9" : (m_ob != int'(req_bank) ? "R6" : "R7"));
      if (!(m_open && hit && !m_pol)) push(1, req_bank, req_row, "R10");
      push(req_write ? 3 : 2, req_bank, req_col, (m_open && hit && !m_pol) ? "R5" : "R11");
      if (m_pol) push(4, req_bank, 0, "R8");
    end
  end

  task automatic req(bit pol, bit wr, int b, int r, int c);
    @(posedge clk); #2;
    close_pol = pol; req_write = wr; req_bank = BANK_W'(b);
    req_row = ROW_W'(r); req_col = COL_W'(c); req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2 req_valid = 1'b0;
    do @(negedge clk); while (!done);
  endtask

  task automatic finish_up();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    bit [31:0] lfsr;
    repeat (3) @(posedge clk);
    #2;
    chk(cmd == 3'd0 && cmd_addr == '0, "R1 reset deselect", cmd, 0);
    chk(req_ready == 1'b1, "R2 reset ready", req_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // open policy: empty, hits, row miss, bank miss
    req(0, 0, 1, 100, 5);
    req(0, 0, 1, 100, 6);
    req(0, 1, 1, 100, 7);
    req(0, 0, 1, 100, 8);
    req(0, 1, 1, 100, 9);
    req(0, 0, 1, 200, 1);
    req(0, 0, 2, 200, 2);
    // policy switch with open row, same bank and row
    req(1, 1, 2, 200, 3);
    req(1, 0, 2, 200, 4);
    req(1, 1, 3, 7, 1023);
    req(0, 1, 0, 8191, 0);
    req(0, 1, 0, 8191, 1);
    repeat (4) @(posedge clk);
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      req(lfsr[3] & lfsr[4], lfsr[5], int'(lfsr[7:6]), int'(lfsr[9:8]), int'(lfsr[19:10]));
    end
    repeat (10) @(posedge clk);
    finish_up();
  end
endmodule